// File: doc/BRIEF.md
# PWM-Shaped Tone Sounder

This block drives a speaker or buzzer pin with a square-wave tone whose loudness is set by an 8-bit pulse-width modulator. The modulator is a 256-step counter. A prescaler clocks it at the system clock divided by 1, 2, 4 or 8. With a 16 MHz clock this gives carrier rates of about 62.5, 31.2, 15.6 and 7.8 kHz.

A second 8-bit counter steps once per carrier period rather than once per system clock. Each time it runs out it flips a tone level. The tone frequency is therefore the carrier rate divided by 2 and by (reload + 1). The pin carries the tone gated by the carrier: the tone is audible, and the duty value acts as a volume control.

Software configures the block through a synchronous write port with a 2-bit address and an 8-bit data bus. Address 0 holds the run bit and the divider select. Address 1 holds the duty. Address 2 holds the reload value. New settings take hold only at carrier-period boundaries, so no truncated or stretched period is ever produced.

Top module: `tone_pwm_sounder`

## Requirements
- R1: While reset is asserted and after it is released, the block is stopped and `pwmOut`, `toneOut` and `soundOut` are low; all settings read as zero.
- R2: A write with `wrEn` high stores `wrData` at the next clock edge. Address 0 stores the run bit from data bit 0 and the divider select from bits 2:1. Address 1 stores the duty and address 2 stores the reload value. A write to address 3 changes nothing.
- R3: While running with divider select `s`, the carrier counter advances once every 2^s clocks, so one carrier period lasts 256·2^s clocks.
- R4: `pwmOut` is high while the carrier count is below the duty in force. Duty 0 keeps it low for the whole period, and duty 255 keeps it high for 255 of the 256 steps.
- R5: At each carrier-period end the tone counter decrements. When it is already zero, it instead loads the stored reload value and `toneOut` inverts, so each tone half-cycle lasts (reload + 1) carrier periods.
- R6: `soundOut` is high exactly when `pwmOut` and `toneOut` are both high.
- R7: Duty and divider select written while running take effect only at the next carrier-period boundary. The reload value is picked up only when the tone counter next expires.
- R8: Clearing the run bit forces `pwmOut` and `soundOut` low from the cycle after the write. On the following edge it zeroes the prescaler, the carrier counter and the tone counter and drops `toneOut`. While stopped, the stored settings are copied into force.
- R9: After the run bit is set, the tone stays low for the whole first carrier period and goes high at its end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the settings port |
| wrAddr | input | 2 | Setting select: 0 run/divider, 1 duty, 2 reload |
| wrData | input | 8 | Write data |
| pwmOut | output | 1 | Raw carrier pulse train |
| toneOut | output | 1 | Tone square-wave level |
| soundOut | output | 1 | Tone gated by carrier, to the pin |

## Verification
The bench aims at the period edges. A duty change in the middle of a period must not alter the current pulse. If it did, the bench would see one pulse of the wrong width. A divider change must not cut a period short either. A design that applied it at once would show a high count that matches no integer multiple of the step size.

The bench times tone toggles at the fastest and slowest dividers, where an off-by-one in the reload handling shifts each half-cycle by a whole carrier period. It also checks the first period after start, which a design that seeds the tone counter wrongly would get wrong.

Further checks show that the unused address leaves the output running, and that stopping silences the pin at once. A design that cleared only the counters would leak one more period of sound after the stop.

// File: rtl/sounder_pkg.sv
package sounder_pkg;

  // Strobes issued by the sequencing control to the datapath each cycle.
  typedef struct packed {
    logic clear;      // block stopped: hold counters at zero
    logic tick;       // carrier counter advances this cycle
    logic periodEnd;  // last step of a carrier period
  } strobeT;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_DUTY   = 2'd1;
  localparam logic [1:0] ADDR_RELOAD = 2'd2;

endpackage

// File: rtl/sounder_regs.sv
module sounder_regs
  import sounder_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int DUTY_W   = 8,
  parameter int RELOAD_W = 8,
  parameter int SEL_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          wrAddr,
  input  logic [BUS_W-1:0]    wrData,
  output logic                enable,
  output logic [SEL_W-1:0]    selReg,
  output logic [DUTY_W-1:0]   dutyReg,
  output logic [RELOAD_W-1:0] reloadReg
);

  localparam int SEL_LO = 1;
  localparam int SEL_HI = SEL_LO + SEL_W - 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable    <= 1'b0;
      selReg    <= '0;
      dutyReg   <= '0;
      reloadReg <= '0;
    end else if (wrEn) begin
      unique case (wrAddr)
        ADDR_CTRL: begin
          enable <= wrData[0];
          selReg <= wrData[SEL_HI:SEL_LO];
        end
        ADDR_DUTY:   dutyReg   <= wrData[DUTY_W-1:0];
        ADDR_RELOAD: reloadReg <= wrData[RELOAD_W-1:0];
        default: ;
      endcase
    end
  end

  // R2: the spare address leaves every setting untouched
  p_spare_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd3) |=> $stable({enable, selReg, dutyReg, reloadReg}));

endmodule

// File: rtl/sounder_ctrl.sv
module sounder_ctrl
  import sounder_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [SEL_W-1:0] selReg,
  input  logic             pwmAtTop,
  output strobeT           strb
);

  // Largest divider is 2**(2**SEL_W - 1); the prescaler needs that many bits.
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] selAct;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;

  always_comb begin
    preMask        = PRE_W'((1 << selAct) - 1);
    strb.clear     = !enable;
    strb.tick      = enable && (preCnt == preMask);
    strb.periodEnd = strb.tick && pwmAtTop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      selAct <= '0;
    end else if (!enable) begin
      preCnt <= '0;
      selAct <= selReg;
    end else begin
      if (strb.tick) preCnt <= '0;
      else           preCnt <= preCnt + 1'b1;
      if (strb.periodEnd) selAct <= selReg;
    end
  end

  // R3: prescaler never runs past the divider in force
  p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preMask);

  // R7: divider in force changes only at a period end while running
  p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !strb.periodEnd) |=> $stable(selAct));

  // R8: stopping zeroes the prescaler on the next edge
  p_pre_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> preCnt == '0);

endmodule

// File: rtl/sounder_datapath.sv
module sounder_datapath
  import sounder_pkg::*;
#(
  parameter int DUTY_W   = 8,
  parameter int RELOAD_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strb,
  input  logic [DUTY_W-1:0]   dutyReg,
  input  logic [RELOAD_W-1:0] reloadReg,
  output logic                pwmAtTop,
  output logic                pwmOut,
  output logic                toneOut,
  output logic                soundOut
);

  logic [DUTY_W-1:0]   pwmCnt;
  logic [DUTY_W-1:0]   dutyAct;
  logic [RELOAD_W-1:0] toneCnt;
  logic                toneLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmCnt  <= '0;
      dutyAct <= '0;
      toneCnt <= '0;
      toneLvl <= 1'b0;
    end else if (strb.clear) begin
      pwmCnt  <= '0;
      toneCnt <= '0;
      toneLvl <= 1'b0;
      dutyAct <= dutyReg;
    end else if (strb.tick) begin
      pwmCnt <= pwmCnt + 1'b1;
      if (strb.periodEnd) begin
        dutyAct <= dutyReg;
        if (toneCnt == '0) begin
          toneCnt <= reloadReg;
          toneLvl <= !toneLvl;
        end else begin
          toneCnt <= toneCnt - 1'b1;
        end
      end
    end
  end

  always_comb begin
    pwmAtTop = &pwmCnt;
    pwmOut   = !strb.clear && (pwmCnt < dutyAct);
    toneOut  = toneLvl;
    soundOut = pwmOut && toneLvl;
  end

  // R7: duty in force holds between period boundaries
  p_duty_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clear && !strb.periodEnd) |=> $stable(dutyAct));

  // R5: tone level only moves at a period end or on a stop
  p_tone_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(toneLvl) |-> ($past(strb.periodEnd) || $past(strb.clear)));

  // R8: a stop zeroes the counters and drops the tone
  p_stop_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (pwmCnt == '0 && toneCnt == '0 && !toneLvl));

  // R4: carrier counter only moves on a tick
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.clear) |=> $stable(pwmCnt));

endmodule

// File: rtl/tone_pwm_sounder.sv
module tone_pwm_sounder
  import sounder_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int DUTY_W   = 8,
  parameter int RELOAD_W = 8,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [BUS_W-1:0] wrData,
  output logic             pwmOut,
  output logic             toneOut,
  output logic             soundOut
);

  logic                enable;
  logic [SEL_W-1:0]    selReg;
  logic [DUTY_W-1:0]   dutyReg;
  logic [RELOAD_W-1:0] reloadReg;
  logic                pwmAtTop;
  strobeT              strb;

  sounder_regs #(
    .BUS_W(BUS_W), .DUTY_W(DUTY_W), .RELOAD_W(RELOAD_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .enable(enable), .selReg(selReg), .dutyReg(dutyReg), .reloadReg(reloadReg)
  );

  sounder_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .selReg(selReg),
    .pwmAtTop(pwmAtTop), .strb(strb)
  );

  sounder_datapath #(.DUTY_W(DUTY_W), .RELOAD_W(RELOAD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dutyReg(dutyReg),
    .reloadReg(reloadReg), .pwmAtTop(pwmAtTop), .pwmOut(pwmOut),
    .toneOut(toneOut), .soundOut(soundOut)
  );

  // R6: the pin is never high without the tone
  p_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    !toneOut |-> !soundOut);

endmodule

// File: tb/tone_pwm_sounder_tb.sv
module tone_pwm_sounder_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       pwmOut, toneOut, soundOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tone_pwm_sounder u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .toneOut(toneOut), .soundOut(soundOut)
  );

  // Behavioural reference: settings, divider phase, step, tone count.
  int mEn, mSelR, mDutyR, mRelR;
  int mSelA, mDutyA, mPre, mStep, mTcnt, mTone;

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mSelR = 0; mDutyR = 0; mRelR = 0;
      mSelA = 0; mDutyA = 0; mPre = 0; mStep = 0; mTcnt = 0; mTone = 0;
    end else begin
      if (mEn == 0) begin
        mPre = 0; mStep = 0; mTcnt = 0; mTone = 0;
        mDutyA = mDutyR; mSelA = mSelR;
      end else if (mPre == (1 << mSelA) - 1) begin
        mPre = 0;
        if (mStep == 255) begin
          mStep = 0; mDutyA = mDutyR; mSelA = mSelR;
          if (mTcnt == 0) begin mTcnt = mRelR; mTone = 1 - mTone; end
          else mTcnt = mTcnt - 1;
        end else mStep = mStep + 1;
      end else mPre = mPre + 1;
      if (wrEn) begin
        case (wrAddr)
          2'd0: begin mEn = int'(wrData[0]); mSelR = int'(wrData[2:1]); end
          2'd1: mDutyR = int'(wrData);
          2'd2: mRelR = int'(wrData);
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the reference, away from the edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      int ePwm;
      ePwm = (mEn != 0 && mStep < mDutyA) ? 1 : 0;
      check("R4 pwmOut vs model", int'(pwmOut), ePwm);
      check("R5 toneOut vs model", int'(toneOut), mTone);
      check("R6 soundOut vs model", int'(soundOut), ePwm & mTone);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic countPwm(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c += int'(pwmOut);
    end
  endtask

  task automatic countTone(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c += int'(toneOut);
    end
  endtask

  // Cycles from now until toneOut next changes.
  task automatic toneGap(output int n);
    logic prev;
    n = 0;
    @(negedge clk);
    prev = toneOut;
    while (toneOut == prev) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c;
    int g;
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    check("R1 pwmOut in reset", int'(pwmOut), 0);
    check("R1 soundOut in reset", int'(soundOut), 0);
    rstN = 1'b1;
    countPwm(20, c);
    check("R1 pwmOut idle after reset", c, 0);

    // R2: spare address with all bits set does not start the block
    wr(2'd1, 8'd128);
    wr(2'd3, 8'hFF);
    countPwm(600, c);
    check("R2 spare address leaves block stopped", c, 0);

    // R9 and R5: start at divider 1, reload 1
    wr(2'd1, 8'd64);
    wr(2'd2, 8'd1);
    wr(2'd0, 8'h01);
    countTone(250, c);
    check("R9 tone low in first period", c, 0);
    toneGap(g);
    toneGap(g);
    check("R5 tone half-cycle reload 1 div 1", g + 1, 512);

    // R7: duty change mid-period, followed by the model cycle by cycle
    repeat (100) @(negedge clk);
    wr(2'd1, 8'd200);
    repeat (700) @(negedge clk);

    // R4: extreme duties over one full period window
    wr(2'd1, 8'd255);
    repeat (600) @(negedge clk);
    countPwm(256, c);
    check("R4 duty 255 high steps", c, 255);
    wr(2'd1, 8'd0);
    repeat (600) @(negedge clk);
    countPwm(256, c);
    check("R4 duty 0 high steps", c, 0);

    // R3 and R7: divider 4, applied at a boundary
    wr(2'd1, 8'd255);
    wr(2'd0, 8'h05);
    repeat (2200) @(negedge clk);
    countPwm(1024, c);
    check("R3 divider 4 period high count", c, 1020);

    // R2: spare write while running keeps it running
    wr(2'd3, 8'h00);
    countPwm(1024, c);
    check("R2 spare write keeps carrier", c, 1020);

    // R8: stop silences the pin
    wr(2'd0, 8'h00);
    check("R8 soundOut after stop", int'(soundOut), 0);
    check("R8 pwmOut after stop", int'(pwmOut), 0);
    @(negedge clk);
    check("R8 toneOut after stop", int'(toneOut), 0);
    countPwm(500, c);
    check("R8 carrier silent while stopped", c, 0);

    // R5 and R3: slowest divider, reload 2
    wr(2'd2, 8'd2);
    wr(2'd0, 8'h07);
    toneGap(g);
    toneGap(g);
    check("R5 tone half-cycle reload 2 div 8", g + 1, 6144);
    repeat (300) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule